// File: doc/BRIEF.md
# Guarded Firmware Image Load Port

This block is a byte-wide register slave that takes in a fixed-size firmware configuration image and streams each accepted byte out on a valid-qualified output. Loading is guarded in two ways. A ready flag stays low until a set number of time-base ticks have passed since reset. Once ready is set, a software agent must write a key value to the start register three times in a row, with no other bus access in between. Only then does the block enter its loading state and accept bytes through the data register.

While it is loading, every write to the data register is forwarded on the byte stream and added to a byte counter. When the counter reaches the image size, the block sets its completion flag, clears its busy flag and ignores any further data. Reads of the data register always return the byte most recently accepted. Reads of the two count registers return the current count, split into a low byte and a high byte. Storing the image and checking it are left to the logic that consumes the byte stream.

Top module: `fwLoadPort`

## Requirements
- R1: After reset the status register (address 0) reads 0x00, the data register (address 2) reads 0x00, both count registers (addresses 3 and 4) read 0x00, and byteValid is low.
- R2: Status bit 0 (ready) reads 0 until READY_TICKS cycles with tick high have been counted since reset, and reads 1 from then on.
- R3: While ready is 0, writes to the start register (address 1) have no effect: they neither begin loading nor count toward the start sequence once ready rises.
- R4: With ready set and the block idle, three writes of 0xA5 to address 1, with no other bus access between them, set status bit 1 (busy) to 1. Idle cycles with no access do not break the sequence.
- R5: During the start sequence, any read of any register (including address 1), or any write to another address, clears the sequence so that three fresh key writes are needed.
- R6: A write to address 1 with any value other than 0xA5 clears the start sequence.
- R7: A data write (address 2) made while busy is 0 is ignored: byteValid stays low, the count is unchanged and the data register keeps its value.
- R8: While busy, each write to address 2 raises byteValid for exactly one cycle after the write edge, with byteData equal to the written byte, and increases the count by one.
- R9: Any number of reads of address 2 return the most recently accepted byte.
- R10: Address 3 returns count bits 7:0 and address 4 returns the upper count bits, zero-extended. Any other unmapped address reads 0x00.
- R11: When the count reaches IMAGE_BYTES, status bit 2 (done) reads 1 and busy reads 0. Further data writes are ignored and the count stays at IMAGE_BYTES.
- R12: After done is set, a new start sequence has no effect: busy stays 0 and done stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base pulse counted for the post-reset delay |
| busAddr | input | ADDR_W | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, updated on the edge that samples busRd |
| byteValid | output | 1 | One-cycle strobe for each accepted image byte |
| byteData | output | 8 | Accepted image byte |

## Verification
The assertions assume a bus master that never raises read and write in the same cycle and that keeps addresses within the mapped range or treats unmapped ones as plain accesses. They also assume that tick is a single-cycle pulse. The stimulus drives at most one strobe per cycle and holds it for one cycle. Ticks are only issued as isolated one-cycle pulses. The random phases draw addresses from a small window that includes unmapped ones, so sequence-breaking accesses stay legal bus traffic.

// File: rtl/fw_load_pkg.sv
`timescale 1ns/1ps
package fw_load_pkg;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_LOAD = 2'd1,
    LD_DONE = 2'd2
  } loadState_e;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic ready;
    logic busy;
    logic done;
    logic acceptByte;
  } ctrlStrobe_t;

  localparam int unsigned REG_STATUS = 0;
  localparam int unsigned REG_START  = 1;
  localparam int unsigned REG_DATA   = 2;
  localparam int unsigned REG_CNT_LO = 3;
  localparam int unsigned REG_CNT_HI = 4;

  localparam logic [7:0] START_KEY = 8'hA5;
  localparam int unsigned SEQ_LEN  = 3;

endpackage

// File: rtl/fwLoadCtrl.sv
`timescale 1ns/1ps
module fwLoadCtrl
  import fw_load_pkg::*;
#(
  parameter int unsigned READY_TICKS = 3000,
  parameter int unsigned ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWrData,
  input  logic              lastSlot,
  output ctrlStrobe_t       strobes
);

  localparam int unsigned TW = $clog2(READY_TICKS + 1);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(REG_START);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(REG_DATA);
  localparam logic [1:0] SEQ_LAST = 2'(SEQ_LEN - 1);

  logic [TW-1:0] tickCnt;
  logic          ready;
  logic [1:0]    seqCnt;
  loadState_e    state;
  logic          access;
  logic          goodStart;
  logic          acceptByte;

  // post-reset delay measured in time-base ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      ready   <= 1'b0;
    end else if (!ready && tick) begin
      if (tickCnt == TW'(READY_TICKS - 1)) ready <= 1'b1;
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign access     = busWr | busRd;
  assign goodStart  = busWr && (busAddr == A_START) && (busWrData == START_KEY);
  assign acceptByte = (state == LD_LOAD) && busWr && (busAddr == A_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= LD_IDLE;
      seqCnt <= '0;
    end else begin
      unique case (state)
        LD_IDLE: begin
          if (ready && access) begin
            if (goodStart) begin
              if (seqCnt == SEQ_LAST) begin
                state  <= LD_LOAD;
                seqCnt <= '0;
              end else begin
                seqCnt <= seqCnt + 1'b1;
              end
            end else begin
              seqCnt <= '0;
            end
          end
        end
        LD_LOAD: begin
          if (acceptByte && lastSlot) state <= LD_DONE;
        end
        default: state <= LD_DONE;
      endcase
    end
  end

  assign strobes.ready      = ready;
  assign strobes.busy       = (state == LD_LOAD);
  assign strobes.done       = (state == LD_DONE);
  assign strobes.acceptByte = acceptByte;

  p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  p_unready_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (seqCnt == 2'd0 && state == LD_IDLE));

  p_seq_enter_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == LD_IDLE && ready && goodStart && seqCnt == SEQ_LAST) |=> state == LD_LOAD);

  p_seq_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == LD_IDLE && ready && access && !goodStart) |=> (seqCnt == 2'd0 && state == LD_IDLE));

  p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == LD_DONE) |=> (state == LD_DONE));

endmodule

// File: rtl/fwLoadData.sv
`timescale 1ns/1ps
module fwLoadData
  import fw_load_pkg::*;
#(
  parameter int unsigned IMAGE_BYTES = 7600,
  parameter int unsigned ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic [7:0]        busWrData,
  input  ctrlStrobe_t       strobes,
  output logic              lastSlot,
  output logic [7:0]        busRdData,
  output logic              byteValid,
  output logic [7:0]        byteData
);

  localparam int unsigned CW = $clog2(IMAGE_BYTES + 1);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(REG_DATA);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(REG_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(REG_CNT_HI);

  logic [CW-1:0] count;
  logic [15:0]   countWide;
  logic [7:0]    lastByte;
  logic [7:0]    rdNext;

  assign lastSlot  = (count == CW'(IMAGE_BYTES - 1));
  assign countWide = 16'(count);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      lastByte  <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= strobes.acceptByte;
      if (strobes.acceptByte) begin
        count    <= count + 1'b1;
        lastByte <= busWrData;
        byteData <= busWrData;
      end
    end
  end

  always_comb begin
    unique case (busAddr)
      A_STATUS: rdNext = {5'b0, strobes.done, strobes.busy, strobes.ready};
      A_DATA:   rdNext = lastByte;
      A_CNT_LO: rdNext = countWide[7:0];
      A_CNT_HI: rdNext = countWide[15:8];
      default:  rdNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)      busRdData <= 8'h00;
    else if (busRd) busRdData <= rdNext;
  end

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(IMAGE_BYTES));

  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.acceptByte |=> $stable(count));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.acceptByte |=> (count == $past(count) + 1'b1));

  p_stream_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.acceptByte |=> (byteValid && byteData == $past(busWrData)));

  p_last_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.acceptByte |=> $stable(lastByte));

endmodule

// File: rtl/fwLoadPort.sv
`timescale 1ns/1ps
module fwLoadPort
  import fw_load_pkg::*;
#(
  parameter int unsigned IMAGE_BYTES = 7600,
  parameter int unsigned READY_TICKS = 3000,
  parameter int unsigned ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              byteValid,
  output logic [7:0]        byteData
);

  ctrlStrobe_t strobes;
  logic        lastSlot;

  fwLoadCtrl #(
    .READY_TICKS(READY_TICKS),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWrData(busWrData),
    .lastSlot (lastSlot),
    .strobes  (strobes)
  );

  fwLoadData #(
    .IMAGE_BYTES(IMAGE_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWrData(busWrData),
    .strobes  (strobes),
    .lastSlot (lastSlot),
    .busRdData(busRdData),
    .byteValid(byteValid),
    .byteData (byteData)
  );

endmodule

// File: tb/fwLoadPort_tb.sv
`timescale 1ns/1ps
module fwLoadPort_tb;

  localparam int IMAGE = 7600;
  localparam int RT    = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tick = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWr = 1'b0;
  logic          busRd = 1'b0;
  logic [7:0]    busWrData = '0;
  logic [7:0]    busRdData;
  logic          byteValid;
  logic [7:0]    byteData;

  always #5 clk = ~clk;

  fwLoadPort #(.IMAGE_BYTES(IMAGE), .READY_TICKS(RT), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWrData(busWrData), .busRdData(busRdData),
    .byteValid(byteValid), .byteData(byteData)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model
  bit       expReady = 0;
  bit       expBusy = 0;
  bit       expDone = 0;
  int       expSeq = 0;
  int       expCount = 0;
  bit [7:0] expLast = 8'h00;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit [7:0] expRead(int a);
    case (a)
      0: return {5'b0, expDone, expBusy, expReady};
      2: return expLast;
      3: return 8'(expCount);
      4: return 8'(expCount >> 8);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagFor(int a);
    case (a)
      0: return "R4";
      2: return "R9";
      3, 4: return "R10";
      default: return "R10";
    endcase
  endfunction

  task automatic doWrite(int a, bit [7:0] d, string req);
    bit acc;
    acc = expBusy && (a == 2);
    @(negedge clk);
    busAddr = AW'(a); busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    check(byteValid == acc, acc ? "R8" : req, "byteValid", int'(byteValid), int'(acc));
    if (acc) check(byteData == d, "R8", "byteData", int'(byteData), int'(d));
    if (expReady && !expBusy && !expDone) begin
      if (a == 1 && d == 8'hA5) begin
        expSeq++;
        if (expSeq == 3) begin expBusy = 1; expSeq = 0; end
      end else expSeq = 0;
    end else if (acc) begin
      expCount++;
      expLast = d;
      if (expCount == IMAGE) begin expBusy = 0; expDone = 1; end
    end
  endtask

  task automatic doRead(int a, string req);
    bit [7:0] e;
    e = expRead(a);
    @(negedge clk);
    busAddr = AW'(a); busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    check(busRdData == e, req, $sformatf("read addr %0d", a), int'(busRdData), int'(e));
    if (expReady && !expBusy && !expDone) expSeq = 0;
  endtask

  task automatic pulseTicks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    doRead(0, "R1");
    doRead(2, "R1");
    doRead(3, "R1");
    doRead(4, "R1");
    check(byteValid == 1'b0, "R1", "byteValid after reset", int'(byteValid), 0);

    // R2 not ready one tick short
    pulseTicks(RT - 1);
    doRead(0, "R2");

    // R3 start writes while unready are ignored
    doWrite(1, 8'hA5, "R3");
    doWrite(1, 8'hA5, "R3");
    doWrite(1, 8'hA5, "R3");
    doWrite(2, 8'h3C, "R7");
    doRead(0, "R3");
    doRead(2, "R7");

    pulseTicks(1);
    expReady = 1;
    doRead(0, "R2");

    // R3 no carried-over sequence: one key write must not start loading
    doWrite(1, 8'hA5, "R3");
    doRead(0, "R3");

    // R5 break by read of another register
    doWrite(1, 8'hA5, "R5"); doWrite(1, 8'hA5, "R5");
    doRead(3, "R5");
    doWrite(1, 8'hA5, "R5");
    doRead(0, "R5");
    // R5 break by read of start register
    doWrite(1, 8'hA5, "R5"); doWrite(1, 8'hA5, "R5");
    doRead(1, "R5");
    doWrite(1, 8'hA5, "R5");
    doRead(0, "R5");
    // R5 break by write to another register
    doWrite(1, 8'hA5, "R5"); doWrite(1, 8'hA5, "R5");
    doWrite(5, 8'hA5, "R5");
    doWrite(1, 8'hA5, "R5");
    doRead(0, "R5");
    // R6 wrong key value
    doWrite(1, 8'hA5, "R6"); doWrite(1, 8'hA5, "R6");
    doWrite(1, 8'h5A, "R6");
    doWrite(1, 8'hA5, "R6");
    doRead(0, "R6");
    // R7 data write while idle and ready
    doWrite(2, 8'h77, "R7");
    doRead(3, "R7");
    doRead(2, "R7");

    // random pre-start traffic
    for (int i = 0; i < 150; i++) begin
      int a;
      bit [7:0] d;
      a = int'($urandom % 8);
      if ($urandom % 2) a = 1;
      d = ($urandom % 3 == 0) ? 8'hA5 : 8'($urandom);
      if ($urandom % 4 == 0) doRead(a, tagFor(a));
      else doWrite(a, d, (a == 1) ? "R6" : "R7");
    end

    // R4 directed start with idle gaps
    if (!expBusy && !expDone) begin
      doWrite(1, 8'hA5, "R4");
      repeat (2) @(negedge clk);
      doWrite(1, 8'hA5, "R4");
      doWrite(1, 8'hA5, "R4");
    end
    doRead(0, "R4");

    // R8/R9/R10 random load phase
    for (int i = 0; i < 40000 && !expDone; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 7) doWrite(2, 8'($urandom), "R8");
      else if (r == 7) begin doRead(2, "R9"); doRead(2, "R9"); end
      else if (r == 8) begin doRead(3, "R10"); doRead(4, "R10"); end
      else begin
        int a;
        a = int'($urandom % 8);
        if (a == 2) a = 6;
        if ($urandom % 2) doRead(a, tagFor(a));
        else doWrite(a, 8'($urandom), "R8");
      end
    end

    // R11 completion
    check(expDone == 1'b1, "R11", "model reached done", int'(expDone), 1);
    doRead(0, "R11");
    doRead(3, "R11");
    doRead(4, "R11");
    doWrite(2, 8'hEE, "R11");
    doRead(3, "R11");
    doRead(2, "R11");
    // R12 restart attempt after done
    doWrite(1, 8'hA5, "R12");
    doWrite(1, 8'hA5, "R12");
    doWrite(1, 8'hA5, "R12");
    doRead(0, "R12");
    doWrite(2, 8'h11, "R12");
    doRead(4, "R12");

    finished = 1;
    summary();
  end

endmodule